// File: doc/BRIEF.md
# Variable-Page TLB Lookup and Permission Check

This block is the lookup stage of a fully associative unified translation buffer. It holds a table of entries. Each entry carries a virtual page number, a physical page number, an address-space identifier, a valid bit, a shared bit, a two-bit page-size code, two protection bits and a dirty bit. Entries are loaded through a plain indexed write port. A page can be 1 KB, 4 KB, 64 KB or 1 MB, so every entry compares a different number of upper address bits.

A lookup request brings a 32-bit virtual address, the current address-space identifier, an access kind (read, write or instruction fetch), the privilege level and a single-virtual-space mode flag. One cycle later the block returns a registered result. The result says whether the address hit, missed or matched more than one entry. It also gives the translated physical address and a fault code that names the exception a processor should take. A six-bit replacement pointer advances on every lookup. Refill software uses it to choose the next entry to overwrite.

Top module: `vtlb_lookup`

## Requirements
- R1: The size code selects the page size: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. An entry's page starts at its VPN shifted left by 10 with the bits below the page size forced to zero. A virtual address matches when its bits above the page size equal that start address.
- R2: The address-space identifier must match unless either of two conditions holds. The entry's shared bit is set, or the single-virtual flag is set during a privileged access. In either case the identifier is ignored.
- R3: An entry whose valid bit is clear never matches. When two or more entries match, the result is a multiple hit with code 0x140. The hit flag is then low.
- R4: Access kind encoding: 01 is a write, and every other value (00 read, 10 fetch) is read-like. When nothing matches, the code is 0x060 for a write and 0x040 for a read-like access.
- R5: A user-mode access to a matching entry whose protection bit 1 is clear is a violation. The code is 0x0A0 for read-like accesses and 0x0C0 for writes. This check takes precedence over R6.
- R6: A write to an entry whose protection bit 0 is clear gets code 0x0C0. A write to a writable entry whose dirty bit is clear gets code 0x080.
- R7: When the access succeeds, the code is 0x000 and the fault flag is low. The physical address is the PPN shifted left by 10 with the in-page bits cleared, ORed with the in-page bits of the virtual address. When there is any fault, the physical address reads zero.
- R8: The response is registered. The valid flag goes high exactly one cycle after a request strobe and lasts one cycle. The result fields hold their values until the next response.
- R9: The replacement pointer advances by one on each lookup and does not change on entry writes. After an increment it wraps to 0 in two cases: the new value is above a nonzero boundary input, or the new value is above the last entry index.
- R10: Reset clears every entry's valid bit, sets the replacement pointer to 0 and drops the response valid flag.
- R11: A write strobe replaces all fields of the entry chosen by the write index. The next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 6 | Entry index to write |
| wrVpn | input | 22 | Virtual page number (address bits 31:10) |
| wrPpn | input | 22 | Physical page number (address bits 31:10) |
| wrAsid | input | 8 | Address-space identifier of the entry |
| wrValid | input | 1 | Valid bit |
| wrShared | input | 1 | Shared bit (identifier ignored) |
| wrSize | input | 2 | Page-size code |
| wrProt | input | 2 | Protection: bit 1 user access, bit 0 writable |
| wrDirty | input | 1 | Dirty bit |
| reqValid | input | 1 | Lookup request strobe |
| reqVa | input | 32 | Virtual address |
| reqAsid | input | 8 | Current address-space identifier |
| reqKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| privMode | input | 1 | Privileged access |
| singleVirt | input | 1 | Single-virtual-space mode |
| replBound | input | 6 | Replacement wrap boundary (0 = none) |
| rspValid | output | 1 | Result valid pulse |
| rspHit | output | 1 | Exactly one entry matched |
| rspMulti | output | 1 | More than one entry matched |
| rspFault | output | 1 | Fault code is nonzero |
| rspCode | output | 12 | Exception code |
| rspPa | output | 32 | Physical address |
| replPtr | output | 6 | Replacement pointer |

## Verification
The bench places pages of all four sizes and probes the last address inside each page and the first address past it. A design that cleared the wrong number of bits for any size would then hit where it should miss, or the reverse. One entry has a VPN and a PPN whose low bits are set while its page is 1 MB. This catches a datapath that forgets to clear the bits below the page size in the start address or in the output address. The identifier bypass is tried in all four combinations of privilege and single-virtual mode, because a swapped condition would let user code see another address space. The bench also covers an invalid copy of a live entry, a pair of overlapping valid entries, the ordering of the user-access check before the write checks, and both wrap rules of the replacement pointer, including writes that must not move it.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int VA_W   = 32;
  localparam int PN_W   = 22;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic [PN_W-1:0]   vpn;
    logic [PN_W-1:0]   ppn;
    logic [ASID_W-1:0] asid;
    logic              valid;
    logic              shared;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic              dirty;
  } tlbEntry_t;

  typedef struct packed {
    logic writeStb;
    logic captureStb;
  } tlbCtrl_t;

  localparam logic [1:0] KIND_WRITE = 2'b01;

  localparam logic [CODE_W-1:0] CODE_OK       = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060;
  localparam logic [CODE_W-1:0] CODE_FIRST_WR = 12'h080;
  localparam logic [CODE_W-1:0] CODE_PROT_RD  = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR  = 12'h0C0;
  localparam logic [CODE_W-1:0] CODE_MULTI    = 12'h140;

  // Mask of the in-page offset bits for a size code
  function automatic logic [VA_W-1:0] offsetMask(input logic [1:0] sz);
    case (sz)
      2'd0:    offsetMask = 32'h0000_03FF;
      2'd1:    offsetMask = 32'h0000_0FFF;
      2'd2:    offsetMask = 32'h0000_FFFF;
      default: offsetMask = 32'h000F_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/vtlb_ctrl.sv
module vtlb_ctrl
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] replBound,
  output tlbCtrl_t         ctrl,
  output logic [IDX_W-1:0] replPtr
);

  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(NUM_ENTRIES - 1);

  logic [IDX_W:0] nextPtr;
  logic           wrapNow;

  assign ctrl.writeStb   = wrEn;
  assign ctrl.captureStb = reqValid;

  assign nextPtr = {1'b0, replPtr} + 1'b1;
  assign wrapNow = ((replBound != '0) && (nextPtr > {1'b0, replBound}))
                   || (nextPtr > LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replPtr <= '0;
    end else if (reqValid) begin
      replPtr <= wrapNow ? '0 : nextPtr[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/vtlb_datapath.sv
module vtlb_datapath
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbCtrl_t          ctrl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  tlbEntry_t         wrEntry,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [1:0]        reqKind,
  input  logic              privMode,
  input  logic              singleVirt,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMulti,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspCode,
  output logic [VA_W-1:0]   rspPa
);

  tlbEntry_t              table_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                   skipAsid;
  logic                   anyHit;
  logic                   multiHit;
  tlbEntry_t              selEntry;
  logic [VA_W-1:0]        selMask;
  logic                   isWrite;
  logic [CODE_W-1:0]      code;
  logic [VA_W-1:0]        paCalc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) table_q[i] <= '0;
    end else if (ctrl.writeStb) begin
      table_q[wrIdx] <= wrEntry;
    end
  end

  assign skipAsid = singleVirt && privMode;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_match
    logic [VA_W-1:0] pageMask;
    logic [VA_W-1:0] pageBase;
    logic            asidOk;
    assign pageMask  = ~offsetMask(table_q[g].size);
    assign pageBase  = {table_q[g].vpn, 10'b0} & pageMask;
    assign asidOk    = table_q[g].shared || skipAsid || (table_q[g].asid == reqAsid);
    assign hitVec[g] = table_q[g].valid && asidOk && ((reqVa & pageMask) == pageBase);
  end

  assign anyHit   = |hitVec;
  assign multiHit = |(hitVec & (hitVec - 1'b1));

  // OR-select: exact when a single entry matches
  always_comb begin
    selEntry = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hitVec[i]) selEntry = selEntry | table_q[i];
    end
  end

  assign selMask = offsetMask(selEntry.size);
  assign isWrite = (reqKind == KIND_WRITE);

  always_comb begin
    paCalc = '0;
    if (multiHit)                              code = CODE_MULTI;
    else if (!anyHit)                          code = isWrite ? CODE_MISS_WR : CODE_MISS_RD;
    else if (!privMode && !selEntry.prot[1])   code = isWrite ? CODE_PROT_WR : CODE_PROT_RD;
    else if (isWrite && !selEntry.prot[0])     code = CODE_PROT_WR;
    else if (isWrite && !selEntry.dirty)       code = CODE_FIRST_WR;
    else begin
      code   = CODE_OK;
      paCalc = ({selEntry.ppn, 10'b0} & ~selMask) | (reqVa & selMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspMulti <= 1'b0;
      rspFault <= 1'b0;
      rspCode  <= '0;
      rspPa    <= '0;
    end else begin
      rspValid <= ctrl.captureStb;
      if (ctrl.captureStb) begin
        rspHit   <= anyHit && !multiHit;
        rspMulti <= multiHit;
        rspFault <= (code != CODE_OK);
        rspCode  <= code;
        rspPa    <= paCalc;
      end
    end
  end

endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PN_W-1:0]   wrVpn,
  input  logic [PN_W-1:0]   wrPpn,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrValid,
  input  logic              wrShared,
  input  logic [1:0]        wrSize,
  input  logic [1:0]        wrProt,
  input  logic              wrDirty,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVa,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [1:0]        reqKind,
  input  logic              privMode,
  input  logic              singleVirt,
  input  logic [IDX_W-1:0]  replBound,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMulti,
  output logic              rspFault,
  output logic [CODE_W-1:0] rspCode,
  output logic [VA_W-1:0]   rspPa,
  output logic [IDX_W-1:0]  replPtr
);

  tlbCtrl_t  ctrl;
  tlbEntry_t wrEntry;

  assign wrEntry = '{vpn: wrVpn, ppn: wrPpn, asid: wrAsid, valid: wrValid,
                     shared: wrShared, size: wrSize, prot: wrProt, dirty: wrDirty};

  vtlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrEn(wrEn),
    .replBound(replBound), .ctrl(ctrl), .replPtr(replPtr)
  );

  vtlb_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrIdx(wrIdx), .wrEntry(wrEntry),
    .reqVa(reqVa), .reqAsid(reqAsid), .reqKind(reqKind), .privMode(privMode),
    .singleVirt(singleVirt), .rspValid(rspValid), .rspHit(rspHit),
    .rspMulti(rspMulti), .rspFault(rspFault), .rspCode(rspCode), .rspPa(rspPa)
  );

endmodule

// File: rtl/vtlb_lookup_chk.sv
module vtlb_lookup_chk #(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspMulti,
  input logic             rspFault,
  input logic [11:0]      rspCode,
  input logic [31:0]      rspPa,
  input logic [IDX_W-1:0] replPtr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R8
  AST_RSP_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R8
  AST_HIT_MULTI_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rspHit && rspMulti)); // R3
  AST_MULTI_CODE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspMulti |-> rspFault && rspCode == 12'h140); // R3
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspHit && !rspMulti |-> rspCode == 12'h040 || rspCode == 12'h060); // R4
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPa == 32'h0); // R7
  AST_OK_IS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspHit); // R7
  AST_REPL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(replPtr)); // R9
  AST_REPL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && replPtr == LAST |=> replPtr == '0); // R9

endmodule

bind vtlb_lookup vtlb_lookup_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspValid(rspValid),
  .rspHit(rspHit), .rspMulti(rspMulti), .rspFault(rspFault),
  .rspCode(rspCode), .rspPa(rspPa), .replPtr(replPtr)
);

// File: tb/sim_vtlb_lookup.sv
module sim_vtlb_lookup;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [21:0] wrVpn = '0, wrPpn = '0;
  logic [7:0]  wrAsid = '0;
  logic        wrValid = 1'b0, wrShared = 1'b0, wrDirty = 1'b0;
  logic [1:0]  wrSize = '0, wrProt = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVa = '0;
  logic [7:0]  reqAsid = '0;
  logic [1:0]  reqKind = '0;
  logic        privMode = 1'b0, singleVirt = 1'b0;
  logic [5:0]  replBound = '0;
  logic        rspValid, rspHit, rspMulti, rspFault;
  logic [11:0] rspCode;
  logic [31:0] rspPa;
  logic [5:0]  replPtr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  vtlb_lookup u0 (.*);

  // {va, asid, kind, priv, singleVirt, expCode, expPa}
  localparam int NV = 19;
  localparam logic [87:0] VEC [NV] = '{
    {32'h0000_1234, 8'd5, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0020_0234}, // R1 4K hit, R3 invalid twin ignored
    {32'h0000_1FFC, 8'd5, 2'd1, 1'b0, 1'b0, 12'h000, 32'h0020_0FFC}, // R1 4K last word write
    {32'h0000_2000, 8'd5, 2'd0, 1'b0, 1'b0, 12'h040, 32'h0},         // R1 past 4K end
    {32'h0000_83FF, 8'd5, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0030_07FF}, // R1 1K last byte
    {32'h0000_8400, 8'd5, 2'd0, 1'b0, 1'b0, 12'h040, 32'h0},         // R1 past 1K end
    {32'h0000_8010, 8'd5, 2'd1, 1'b0, 1'b0, 12'h0C0, 32'h0},         // R6 read-only page write
    {32'h0010_ABCD, 8'd3, 2'd0, 1'b0, 1'b0, 12'h000, 32'h0040_ABCD}, // R2 shared 64K
    {32'h0010_0004, 8'd3, 2'd1, 1'b0, 1'b0, 12'h080, 32'h0},         // R6 clean page write
    {32'h010F_FFF0, 8'd5, 2'd0, 1'b1, 1'b0, 12'h000, 32'h020F_FFF0}, // R1 1M, low pn bits cleared
    {32'h0100_0000, 8'd5, 2'd0, 1'b0, 1'b0, 12'h0A0, 32'h0},         // R5 user read
    {32'h0100_0000, 8'd5, 2'd1, 1'b0, 1'b0, 12'h0C0, 32'h0},         // R5 user write
    {32'h0100_0010, 8'd5, 2'd2, 1'b0, 1'b0, 12'h0A0, 32'h0},         // R5 user fetch
    {32'h0000_1000, 8'd6, 2'd0, 1'b0, 1'b0, 12'h040, 32'h0},         // R2 asid mismatch
    {32'h0000_1000, 8'd6, 2'd0, 1'b1, 1'b1, 12'h000, 32'h0020_0000}, // R2 priv + single virt
    {32'h0000_1000, 8'd6, 2'd0, 1'b0, 1'b1, 12'h040, 32'h0},         // R2 user + single virt
    {32'h0000_1000, 8'd6, 2'd0, 1'b1, 1'b0, 12'h040, 32'h0},         // R2 priv only
    {32'h0000_5008, 8'd5, 2'd0, 1'b0, 1'b0, 12'h140, 32'h0},         // R3 double hit
    {32'h0000_7000, 8'd5, 2'd1, 1'b0, 1'b0, 12'h060, 32'h0},         // R4 write miss
    {32'h0000_9010, 8'd7, 2'd2, 1'b0, 1'b0, 12'h000, 32'h000C_0010}  // R4 fetch hit
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [5:0] idx, input logic [21:0] vpn, input logic [21:0] ppn,
                            input logic [7:0] asid, input logic v, input logic sh,
                            input logic [1:0] sz, input logic [1:0] pr, input logic d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrVpn = vpn; wrPpn = ppn; wrAsid = asid;
    wrValid = v; wrShared = sh; wrSize = sz; wrProt = pr; wrDirty = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic [1:0] kind,
                        input logic priv, input logic sv);
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqAsid = asid; reqKind = kind;
    privMode = priv; singleVirt = sv;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [11:0] ec;
    doReset();
    check("R10 rspValid after reset", 64'(rspValid), 64'd0);
    check("R10 replPtr after reset", 64'(replPtr), 64'd0);
    lookup(32'h0000_1000, 8'd5, 2'd0, 1'b1, 1'b0);
    check("R10 empty table misses", 64'(rspCode), 64'h040);
    check("R8 response valid pulse", 64'(rspValid), 64'd1);
    @(negedge clk);
    check("R8 response valid drops", 64'(rspValid), 64'd0);
    check("R8 result held", 64'(rspCode), 64'h040);

    writeEntry(6'd0, 22'h4,    22'h800,  8'd5, 1, 0, 2'd1, 2'b11, 1);
    writeEntry(6'd1, 22'h20,   22'hC01,  8'd5, 1, 0, 2'd0, 2'b10, 1);
    writeEntry(6'd2, 22'h400,  22'h1000, 8'd9, 1, 1, 2'd2, 2'b11, 0);
    writeEntry(6'd3, 22'h4003, 22'h8007, 8'd5, 1, 0, 2'd3, 2'b01, 1);
    writeEntry(6'd4, 22'h4,    22'h900,  8'd5, 0, 0, 2'd1, 2'b11, 1);
    writeEntry(6'd5, 22'h14,   22'h100,  8'd5, 1, 0, 2'd1, 2'b11, 1);
    writeEntry(6'd6, 22'h14,   22'h200,  8'd5, 1, 0, 2'd1, 2'b11, 1);
    writeEntry(6'd7, 22'h24,   22'h300,  8'd7, 1, 0, 2'd1, 2'b11, 1);
    check("R9 writes do not advance pointer", 64'(replPtr), 64'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic expHit, expMulti;
      ec = VEC[i][43:32];
      lookup(VEC[i][87:56], VEC[i][55:48], VEC[i][47:46], VEC[i][45], VEC[i][44]);
      case (ec)
        12'h000: tag = "R7";
        12'h040, 12'h060: tag = "R4";
        12'h0A0: tag = "R5";
        12'h140: tag = "R3";
        default: tag = "R6";
      endcase
      expMulti = (ec == 12'h140);
      expHit   = !expMulti && (ec != 12'h040) && (ec != 12'h060);
      check($sformatf("%s/R1/R2 vector %0d", tag, i),
            {rspHit, rspMulti, rspFault, rspCode, rspPa},
            64'({expHit, expMulti, (ec != 12'h0), ec, VEC[i][31:0]}));
    end
    check("R9 pointer after vectors", 64'(replPtr), 64'd20);

    writeEntry(6'd1, 22'h20, 22'hD00, 8'd5, 1, 0, 2'd0, 2'b11, 1);
    lookup(32'h0000_8004, 8'd5, 2'd0, 1'b0, 1'b0);
    check("R11 rewritten entry PA", 64'(rspPa), 64'h0034_0004);
    writeEntry(6'd0, 22'h4, 22'h800, 8'd5, 0, 0, 2'd1, 2'b11, 1);
    lookup(32'h0000_1234, 8'd5, 2'd0, 1'b0, 1'b0);
    check("R11/R3 invalidated entry misses", 64'(rspCode), 64'h040);

    doReset();
    lookup(32'h0000_1234, 8'd5, 2'd0, 1'b0, 1'b0);
    check("R10 reset cleared entries", 64'(rspCode), 64'h040);
    replBound = 6'd3;
    lookup(32'h0, 8'd0, 2'd0, 1'b0, 1'b0);
    lookup(32'h0, 8'd0, 2'd0, 1'b0, 1'b0);
    check("R9 pointer at boundary", 64'(replPtr), 64'd3);
    lookup(32'h0, 8'd0, 2'd0, 1'b0, 1'b0);
    check("R9 wrap above boundary", 64'(replPtr), 64'd0);
    replBound = 6'd0;
    for (int i = 0; i < 63; i++) lookup(32'h0, 8'd0, 2'd0, 1'b0, 1'b0);
    check("R9 pointer at last index", 64'(replPtr), 64'd63);
    lookup(32'h0, 8'd0, 2'd0, 1'b0, 1'b0);
    check("R9 wrap past last index", 64'(replPtr), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule